// File: doc/BRIEF.md
# Per-Queue Saturating Statistics Bank

This block keeps the event statistics for a single receive reorder queue. The window tracker next to it raises one-cycle pulses when a forward is forced by a timeout over a hole, when a block-ack request forces a forward, when a block-ack request arrives, when a frame is late, when the window jumps by 2K or more, when a hole is created, when a duplicate is seen, when a frame is forwarded in order (two kinds of verdict), and when an MPDU or MSDU is processed. It also presents a frame length in bytes. Each pulse moves its own counter by one. The length moves a byte counter by the length rounded up to whole 64-byte units.

Some counters stop at their all-ones value and stay there. The others wrap modulo their width. Software reads the counters as 32-bit words through a combinational select port. A synchronous clear zeroes every counter, and it wins over any increment in the same cycle.

Top module: `queue_stats_bank`

## Requirements
- R1: After reset every readable word (selects 0 to 7) reads zero.
- R2: With `clr` high at a clock edge, every counter is zero after that edge, even when event pulses are high in the same cycle.
- R3: The hole-timeout and request-forced forward counters (6 bits), the request-received counter (8 bits), the late counter (12 bits) and the 2K-jump counter (4 bits) stop at all ones and hold there under further pulses.
- R4: The duplicate (16 bits), hole (16 bits), MPDU (32 bits), MSDU (32 bits) and byte (32 bits) counters wrap to zero past all ones.
- R5: The 24-bit in-order counter gains one for each of `ev_fwd_cur` and `ev_fwd_buf`, so it gains two when both are high in one cycle.
- R6: When `len_vld` is high, the byte counter gains ceil(`len_bytes`/64). A length of 0 adds nothing.
- R7: Select 0 returns the hole-timeout count at bits [9:4], the request-forced count at [15:10] and the duplicate count at [31:16], with bits [3:0] zero.
- R8: Select 1 returns the in-order count at bits [23:0] and the request-received count at [31:24].
- R9: Select 2 returns the late count at bits [11:0], the jump count at [15:12] and the hole count at [31:16].
- R10: Select 3 returns the MPDU count, select 4 the MSDU count and select 5 the byte count. Selects 6 and 7 return zero.
- R11: A pulse changes its counter at the next clock edge. Pulses that fall in the same cycle each update their own counter with no interaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clr | input | 1 | Synchronous clear of all counters |
| ev_tmo_hole | input | 1 | Forward forced by timeout over a hole |
| ev_bar_fwd | input | 1 | Forward forced by a block-ack request |
| ev_bar_rx | input | 1 | Block-ack request received |
| ev_late | input | 1 | Frame arrived behind the window |
| ev_jump | input | 1 | Window moved by 2K or more |
| ev_dup | input | 1 | Duplicate frame detected |
| ev_fwd_cur | input | 1 | In-order verdict, current frame forwarded |
| ev_fwd_buf | input | 1 | In-order verdict, buffered frame forwarded |
| ev_q_cur | input | 1 | Current frame queued, creating a hole |
| ev_mpdu | input | 1 | MPDU processed |
| ev_msdu | input | 1 | MSDU processed |
| len_vld | input | 1 | Frame length present |
| len_bytes | input | LEN_W | Frame length in bytes |
| rd_sel | input | 3 | Word select |
| rd_data | output | 32 | Selected packed word |

## Verification
A clear and an increment can fall in the same cycle. So can two in-order verdicts. The bench raises `clr` together with every event pulse and a length after the counters already hold non-zero values, and it expects all six words to read zero. It also raises `ev_fwd_cur` and `ev_fwd_buf` together and expects the in-order field to grow by two. Both bench expectations are written from the requirements, and matching assertions in the RTL watch these same edges.

// File: rtl/qs_pkg.sv
package qs_pkg;
  localparam int TMO_W  = 6;
  localparam int BFW_W  = 6;
  localparam int BRX_W  = 8;
  localparam int LATE_W = 12;
  localparam int JMP_W  = 4;
  localparam int DUP_W  = 16;
  localparam int INO_W  = 24;
  localparam int HOLE_W = 16;
  localparam int TOT_W  = 32;
  localparam int WORD_W = 32;
  localparam int UNIT_SH = 6;

  typedef enum logic [2:0] {
    SEL_FWD   = 3'd0,
    SEL_ORDER = 3'd1,
    SEL_WIN   = 3'd2,
    SEL_MPDU  = 3'd3,
    SEL_MSDU  = 3'd4,
    SEL_BYTES = 3'd5
  } stat_sel_e;
endpackage

// File: rtl/qs_ctr.sv
module qs_ctr #(
  parameter int W   = 8,
  parameter int IW  = 1,
  parameter bit SAT = 1'b0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [IW-1:0] amt,
  output logic [W-1:0]  cnt
);
  logic [W-1:0] cnt_q, cnt_d;
  logic [W:0]   sum;
  logic         ld;

  assign sum = {1'b0, cnt_q} + (W+1)'(amt);
  assign ld  = clr | (|amt);

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (|amt)
      cnt_d = (SAT && sum[W]) ? '1 : sum[W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      cnt_q <= '0;
    else if (ld)
      cnt_q <= cnt_d;
  end

  assign cnt = cnt_q;

  // R2: clear wins over any increment
  a_r2_clear_zero: assert property (@(posedge clk) disable iff (!rst_n)
    $past(clr) |-> cnt_q == '0);

  generate
    if (SAT) begin : g_sat
      // R3: a full counter stays full
      a_r3_freeze: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(cnt_q) == {W{1'b1}}) && !$past(clr) |-> cnt_q == {W{1'b1}});
    end else begin : g_wrap
      // R4: a full counter stepped by one returns to zero
      a_r4_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $past(amt == IW'(1) && cnt_q == {W{1'b1}} && !clr) |-> cnt_q == '0);
    end
  endgenerate
endmodule

// File: rtl/qs_len_units.sv
module qs_len_units #(
  parameter int LEN_W = 16,
  parameter int SH    = 6,
  localparam int UW   = LEN_W - SH + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LEN_W-1:0] len,
  output logic [UW-1:0]    units
);
  assign units = {1'b0, len[LEN_W-1:SH]} + UW'(|len[SH-1:0]);

  // R6: units cover the length with less than one unit to spare
  a_r6_round: assert property (@(posedge clk) disable iff (!rst_n)
    ((32'(units) << SH) >= 32'(len)) && (((32'(units) << SH) - 32'(len)) < (32'd1 << SH)));
endmodule

// File: rtl/qs_pack.sv
module qs_pack
  import qs_pkg::*;
(
  input  logic [2:0]        sel,
  input  logic [TMO_W-1:0]  tmo,
  input  logic [BFW_W-1:0]  bfw,
  input  logic [BRX_W-1:0]  brx,
  input  logic [LATE_W-1:0] late,
  input  logic [JMP_W-1:0]  jmp,
  input  logic [DUP_W-1:0]  dup,
  input  logic [INO_W-1:0]  ino,
  input  logic [HOLE_W-1:0] hole,
  input  logic [TOT_W-1:0]  mpdu,
  input  logic [TOT_W-1:0]  msdu,
  input  logic [TOT_W-1:0]  bytes,
  output logic [WORD_W-1:0] word
);
  always_comb begin
    word = '0;
    case (stat_sel_e'(sel))
      SEL_FWD:   word = {dup, bfw, tmo, 4'h0};
      SEL_ORDER: word = {brx, ino};
      SEL_WIN:   word = {hole, jmp, late};
      SEL_MPDU:  word = mpdu;
      SEL_MSDU:  word = msdu;
      SEL_BYTES: word = bytes;
      default:   word = '0;
    endcase
  end
endmodule

// File: rtl/queue_stats_bank.sv
module queue_stats_bank
  import qs_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             ev_tmo_hole,
  input  logic             ev_bar_fwd,
  input  logic             ev_bar_rx,
  input  logic             ev_late,
  input  logic             ev_jump,
  input  logic             ev_dup,
  input  logic             ev_fwd_cur,
  input  logic             ev_fwd_buf,
  input  logic             ev_q_cur,
  input  logic             ev_mpdu,
  input  logic             ev_msdu,
  input  logic             len_vld,
  input  logic [LEN_W-1:0] len_bytes,
  input  logic [2:0]       rd_sel,
  output logic [31:0]      rd_data
);
  localparam int UW = LEN_W - UNIT_SH + 1;

  logic [TMO_W-1:0]  tmo_c;
  logic [BFW_W-1:0]  bfw_c;
  logic [BRX_W-1:0]  brx_c;
  logic [LATE_W-1:0] late_c;
  logic [JMP_W-1:0]  jmp_c;
  logic [DUP_W-1:0]  dup_c;
  logic [INO_W-1:0]  ino_c;
  logic [HOLE_W-1:0] hole_c;
  logic [TOT_W-1:0]  mpdu_c, msdu_c, byte_c;
  logic [UW-1:0]     units, units_gated;
  logic [1:0]        ino_amt;

  assign ino_amt     = {1'b0, ev_fwd_cur} + {1'b0, ev_fwd_buf};
  assign units_gated = len_vld ? units : '0;

  qs_len_units #(.LEN_W(LEN_W), .SH(UNIT_SH)) u_units (
    .clk(clk), .rst_n(rst_n), .len(len_bytes), .units(units));

  qs_ctr #(.W(TMO_W),  .IW(1), .SAT(1'b1)) u_tmo  (.clk(clk), .rst_n(rst_n), .clr(clr), .amt(ev_tmo_hole), .cnt(tmo_c));
  qs_ctr #(.W(BFW_W),  .IW(1), .SAT(1'b1)) u_bfw  (.clk(clk), .rst_n(rst_n), .clr(clr), .amt(ev_bar_fwd),  .cnt(bfw_c));
  qs_ctr #(.W(BRX_W),  .IW(1), .SAT(1'b1)) u_brx  (.clk(clk), .rst_n(rst_n), .clr(clr), .amt(ev_bar_rx),   .cnt(brx_c));
  qs_ctr #(.W(LATE_W), .IW(1), .SAT(1'b1)) u_late (.clk(clk), .rst_n(rst_n), .clr(clr), .amt(ev_late),     .cnt(late_c));
  qs_ctr #(.W(JMP_W),  .IW(1), .SAT(1'b1)) u_jmp  (.clk(clk), .rst_n(rst_n), .clr(clr), .amt(ev_jump),     .cnt(jmp_c));
  qs_ctr #(.W(DUP_W),  .IW(1), .SAT(1'b0)) u_dup  (.clk(clk), .rst_n(rst_n), .clr(clr), .amt(ev_dup),      .cnt(dup_c));
  qs_ctr #(.W(INO_W),  .IW(2), .SAT(1'b0)) u_ino  (.clk(clk), .rst_n(rst_n), .clr(clr), .amt(ino_amt),     .cnt(ino_c));
  qs_ctr #(.W(HOLE_W), .IW(1), .SAT(1'b0)) u_hole (.clk(clk), .rst_n(rst_n), .clr(clr), .amt(ev_q_cur),    .cnt(hole_c));
  qs_ctr #(.W(TOT_W),  .IW(1), .SAT(1'b0)) u_mpdu (.clk(clk), .rst_n(rst_n), .clr(clr), .amt(ev_mpdu),     .cnt(mpdu_c));
  qs_ctr #(.W(TOT_W),  .IW(1), .SAT(1'b0)) u_msdu (.clk(clk), .rst_n(rst_n), .clr(clr), .amt(ev_msdu),     .cnt(msdu_c));
  qs_ctr #(.W(TOT_W),  .IW(UW), .SAT(1'b0)) u_byte (.clk(clk), .rst_n(rst_n), .clr(clr), .amt(units_gated), .cnt(byte_c));

  qs_pack u_pack (
    .sel(rd_sel), .tmo(tmo_c), .bfw(bfw_c), .brx(brx_c), .late(late_c), .jmp(jmp_c),
    .dup(dup_c), .ino(ino_c), .hole(hole_c), .mpdu(mpdu_c), .msdu(msdu_c),
    .bytes(byte_c), .word(rd_data));

  // R5: two verdicts in one cycle add two
  a_r5_two_verdicts: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_fwd_cur && ev_fwd_buf && !clr) && ($past(ino_c) < 24'hFFFFFE)
    |-> ino_c == $past(ino_c) + 24'd2);

  // R11: a lone event moves only its own counter
  a_r11_lone_dup: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ev_dup && !clr && !ev_mpdu && !ev_late) |-> $stable(mpdu_c) && $stable(late_c));
endmodule

// File: tb/sim_queue_stats_bank.sv
module sim_queue_stats_bank;
  logic clk = 1'b0;
  logic rst_n;
  logic clr;
  logic ev_tmo_hole, ev_bar_fwd, ev_bar_rx, ev_late, ev_jump, ev_dup;
  logic ev_fwd_cur, ev_fwd_buf, ev_q_cur, ev_mpdu, ev_msdu, len_vld;
  logic [15:0] len_bytes;
  logic [2:0]  rd_sel;
  logic [31:0] rd_data;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  queue_stats_bank u0 (
    .clk(clk), .rst_n(rst_n), .clr(clr),
    .ev_tmo_hole(ev_tmo_hole), .ev_bar_fwd(ev_bar_fwd), .ev_bar_rx(ev_bar_rx),
    .ev_late(ev_late), .ev_jump(ev_jump), .ev_dup(ev_dup),
    .ev_fwd_cur(ev_fwd_cur), .ev_fwd_buf(ev_fwd_buf), .ev_q_cur(ev_q_cur),
    .ev_mpdu(ev_mpdu), .ev_msdu(ev_msdu), .len_vld(len_vld),
    .len_bytes(len_bytes), .rd_sel(rd_sel), .rd_data(rd_data));

  // mask bits: 0 tmo,1 bfw,2 brx,3 late,4 jump,5 dup,6 fcur,7 fbuf,8 qcur,9 mpdu,10 msdu,11 len
  task automatic drive(input logic [11:0] m, input logic c);
    {len_vld, ev_msdu, ev_mpdu, ev_q_cur, ev_fwd_buf, ev_fwd_cur,
     ev_dup, ev_jump, ev_late, ev_bar_rx, ev_bar_fwd, ev_tmo_hole} = m;
    clr = c;
  endtask

  task automatic fire(input logic [11:0] m, input int n, input logic c);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      drive(m, c);
    end
    @(negedge clk);
    drive('0, 1'b0);
  endtask

  task automatic chk(input string tag, input logic [2:0] sel, input logic [31:0] exp);
    rd_sel = sel;
    #1;
    n_chk++;
    if (rd_data !== exp) begin
      n_fail++;
      $display("FAIL %s sel=%0d actual=%h expected=%h", tag, sel, rd_data, exp);
    end
  endtask

  task automatic do_clear;
    fire('0, 1, 1'b1);
  endtask

  task automatic t_reset;
    for (int s = 0; s < 8; s++) chk("R1 reset", 3'(s), 32'h0);
  endtask

  task automatic t_all_at_once;
    do_clear();
    fire(12'h7FF, 1, 1'b0);
    chk("R11 R7 word0", 3'd0, 32'h0001_0410);
    chk("R11 R8 word1", 3'd1, 32'h0100_0002);
    chk("R11 R9 word2", 3'd2, 32'h0001_1001);
    chk("R11 R10 mpdu", 3'd3, 32'd1);
    chk("R11 R10 msdu", 3'd4, 32'd1);
    chk("R10 unused 6", 3'd6, 32'h0);
    chk("R10 unused 7", 3'd7, 32'h0);
  endtask

  task automatic t_inorder;
    do_clear();
    fire(12'h040, 3, 1'b0);
    chk("R5 cur only", 3'd1, 32'd3);
    fire(12'h0C0, 2, 1'b0);
    chk("R5 both verdicts", 3'd1, 32'd7);
    fire(12'h080, 1, 1'b0);
    chk("R5 buf only", 3'd1, 32'd8);
  endtask

  task automatic t_bytes;
    int tot = 0;
    int lens[6] = '{0, 1, 64, 65, 128, 65535};
    int adds[6] = '{0, 1, 1, 2, 2, 1024};
    do_clear();
    for (int k = 0; k < 6; k++) begin
      len_bytes = 16'(lens[k]);
      fire(12'h800, 1, 1'b0);
      tot += adds[k];
      chk("R6 byte units", 3'd5, 32'(tot));
    end
    len_bytes = 16'd200;
    fire(12'h000, 1, 1'b0);
    chk("R6 no vld", 3'd5, 32'(tot));
  endtask

  task automatic t_saturate;
    do_clear();
    fire(12'h001, 70, 1'b0);
    chk("R3 tmo sat", 3'd0, 32'h0000_03F0);
    fire(12'h002, 70, 1'b0);
    chk("R3 bfw sat", 3'd0, 32'h0000_FFF0);
    fire(12'h004, 300, 1'b0);
    chk("R3 brx sat", 3'd1, 32'hFF00_0000);
    fire(12'h008, 4100, 1'b0);
    fire(12'h010, 20, 1'b0);
    chk("R3 late jump sat", 3'd2, 32'h0000_FFFF);
  endtask

  task automatic t_clear_priority;
    len_bytes = 16'd64;
    fire(12'hFFF, 1, 1'b1);
    for (int s = 0; s < 6; s++) chk("R2 clear wins", 3'(s), 32'h0);
  endtask

  task automatic t_wrap;
    do_clear();
    fire(12'h020, 65539, 1'b0);
    chk("R4 dup wrap", 3'd0, 32'h0003_0000);
    fire(12'h100, 65537, 1'b0);
    chk("R4 hole wrap", 3'd2, 32'h0001_0000);
  endtask

  initial begin
    rst_n = 1'b0;
    rd_sel = '0;
    len_bytes = '0;
    drive('0, 1'b0);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_all_at_once();
    t_inorder();
    t_bytes();
    t_saturate();
    t_clear_priority();
    t_wrap();
    if (!done) begin
      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule